// File: doc/BRIEF.md
# Digit-Serial Carry-Save Montgomery Multiply-Add Unit

This block computes a Montgomery multiply-add over a prime field. It keeps its running value in redundant form, as a sum vector VS and a carry vector VC whose value is VS + 2·VC. The multiplicand X and the addend S arrive as digits of DIG bits, least significant digit first. The multiplier Y and the odd modulus N are latched in full-width registers when a multiplication starts. The Montgomery radix is R = 2^W, with W = KW + ALPHA and ALPHA = 4.

A multiply-add runs two passes over the same vectors, each lasting D = W/DIG cycles. In the first pass, each cycle folds one X digit times Y into the carry-save pair. Bit by bit, the lowest cell chooses the quotient bit that clears the lowest position, adds that multiple of N across the whole width, and shifts the pair right. In the second pass the carries are resolved one digit at a time and S is added. Each result digit leaves the block and is also rotated back into VS. An add-only operation runs just the second pass on the stored VS/VC, so results can be chained for modular addition.

The larger radix keeps results small enough to be reused as operands without a final conditional subtraction. (KW + ALPHA) must be a multiple of DIG, and DIG must be at least 2. Both conditions are enforced at elaboration.

Top module: `mont_digit_mul`

## Requirements
- R1: While reset is asserted and after it is released, busy, xLoad, sLoad, outValid and done are all low.
- R2: A multiply-add start (start=1 with opAdd=0 while busy is low) is followed by exactly D cycles with xLoad high and sLoad low. These are followed by exactly D cycles with sLoad high and xLoad low. The X and S digits are consumed in those cycles, least significant digit first.
- R3: For odd N below 2^KW and X, Y, S each below 2·N, the multiply-add result is congruent modulo N to X·Y·2^-W + S and is below 2^(KW+2). No final subtraction is applied.
- R4: Each operation emits exactly D valid result digits, least significant first. Each digit becomes valid one cycle after the cycle that consumed the S digit of the same position. done is high together with the last digit and at no other time.
- R5: A multiply-add shows its last digit 2·D cycles after the start edge. An add-only operation shows its last digit D cycles after the start edge. In the following cycle busy, outValid and done are low.
- R6: An add-only start (start=1 with opAdd=1 while busy is low) skips the X pass and never raises xLoad. It outputs exactly VS + 2·VC + S, taken from the stored pair. After any completed operation that pair holds that operation's result.
- R7: busy is high from the cycle after an accepted start up to and including the cycle that shows the last digit. A start request seen while busy is high has no effect on timing or result.
- R8: A multiply-add clears VS and VC at its start, so its result does not depend on earlier operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| opAdd | input | 1 | With start: 1 selects add-only, 0 selects multiply-add |
| xDigit | input | DIG | Multiplicand digit, read in xLoad cycles |
| sDigit | input | DIG | Addend digit, read in sLoad cycles |
| yIn | input | KW+ALPHA | Multiplier, latched at a multiply-add start |
| nIn | input | KW+ALPHA | Odd modulus, latched at a multiply-add start |
| busy | output | 1 | Operation in progress |
| xLoad | output | 1 | The current cycle consumes xDigit |
| sLoad | output | 1 | The current cycle consumes sDigit |
| outDigit | output | DIG | Result digit |
| outValid | output | 1 | outDigit holds a result digit |
| done | output | 1 | Last result digit of the operation |

## Verification
Several properties are checked on every cycle by the assertions. The pass handover happens after exactly D digit steps. A start seen in the middle of a pass does not disturb the step counter. done never appears without a valid digit. After the last resolve step the carry vector and the digit carry are both zero, which shows that the result fits in W bits without a final subtraction. The numeric results can only be shown by the bench scenarios: the modular congruence across a set of operand patterns, the exact sum of an add-only operation chained onto a stored result, the clearing of VS and VC between multiplications, and the port-level timing of the load strobes.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CS   = 2'd1,
    PH_CP   = 2'd2
  } phase_t;

  // Strobes from the sequencer to the vector datapath
  typedef struct packed {
    logic clrAcc;    // multiply start: zero VS/VC, latch Y and N
    logic clrCarry;  // any start: zero the digit carry
    logic csStep;    // fold one X digit into the carry-save pair
    logic cpStep;    // resolve one digit and add one S digit
    logic lastStep;  // final step of the current pass
  } dpCtl_t;

endpackage

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
#(
  parameter int unsigned STEPS = 9
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   opAdd,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   xLoad,
  output logic   sLoad,
  output logic   outValid,
  output logic   done
);

  localparam int unsigned CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  phase_t phase;
  logic [CW-1:0] cnt;
  logic validReg, doneReg;
  logic startOk, atLast;

  assign busy    = (phase != PH_IDLE) || validReg;
  assign startOk = start && !busy;
  assign atLast  = (cnt == LAST);

  always_comb begin
    ctl.clrAcc   = startOk && !opAdd;
    ctl.clrCarry = startOk;
    ctl.csStep   = (phase == PH_CS);
    ctl.cpStep   = (phase == PH_CP);
    ctl.lastStep = atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      validReg <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      validReg <= (phase == PH_CP);
      doneReg  <= (phase == PH_CP) && atLast;
      unique case (phase)
        PH_IDLE: if (startOk) begin
          phase <= opAdd ? PH_CP : PH_CS;
          cnt   <= '0;
        end
        PH_CS: begin
          cnt <= atLast ? '0 : cnt + 1'b1;
          if (atLast) phase <= PH_CP;
        end
        PH_CP: begin
          cnt <= atLast ? '0 : cnt + 1'b1;
          if (atLast) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign xLoad    = (phase == PH_CS);
  assign sLoad    = (phase == PH_CP);
  assign outValid = validReg;
  assign done     = doneReg;

  // R2: the multiply pass hands over to the resolve pass after its last step
  p_cs_to_cp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CS && atLast) |=> (phase == PH_CP && cnt == '0));

  // R5: the resolve pass ends by going idle with the final digit on show
  p_cp_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CP && atLast) |=> (phase == PH_IDLE && outValid && done));

  // R7: a start seen mid-pass leaves the step counter advancing normally
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CS && !atLast && start) |=> (phase == PH_CS && cnt == $past(cnt) + 1'b1));

  // R4: done only travels with a valid digit
  p_done_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> outValid);

endmodule

// File: rtl/mdm_datapath.sv
module mdm_datapath
  import mdm_pkg::*;
#(
  parameter int unsigned W   = 36,
  parameter int unsigned DIG = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         ctl,
  input  logic [DIG-1:0] xDigit,
  input  logic [DIG-1:0] sDigit,
  input  logic [W-1:0]   yIn,
  input  logic [W-1:0]   nIn,
  output logic [DIG-1:0] outDigit
);

  logic [W-1:0] vsReg, vcReg, yReg, nReg;
  logic [1:0]   cinReg;

  // carry-save pass: DIG bit steps, each choosing a quotient bit at bit 0
  logic [W-1:0] accS, accC, addY, addN, s1, c1, sh;
  logic         qBit;

  always_comb begin
    accS = vsReg;
    accC = vcReg;
    addY = '0;
    addN = '0;
    s1   = '0;
    c1   = '0;
    sh   = '0;
    qBit = 1'b0;
    for (int j = 0; j < DIG; j++) begin
      addY = xDigit[j] ? yReg : '0;
      qBit = accS[0] ^ (xDigit[j] & yReg[0]);
      addN = qBit ? nReg : '0;
      s1   = accS ^ addY ^ addN;
      c1   = (accS & addY) | (accS & addN) | (addY & addN);
      sh   = s1 >> 1;
      accS = sh ^ c1 ^ accC;
      accC = (sh & c1) | (sh & accC) | (c1 & accC);
    end
  end

  // resolve pass: one digit of VS + 2*VC + S per cycle
  logic [DIG+1:0] digSum;
  logic [1:0]     cinNext;

  assign digSum  = {2'b00, vsReg[DIG-1:0]} + {2'b00, vcReg[DIG-2:0], 1'b0}
                 + {2'b00, sDigit} + {{DIG{1'b0}}, cinReg};
  assign cinNext = digSum[DIG+1:DIG] + {1'b0, vcReg[DIG-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsReg    <= '0;
      vcReg    <= '0;
      yReg     <= '0;
      nReg     <= '0;
      cinReg   <= '0;
      outDigit <= '0;
    end else begin
      if (ctl.clrAcc) begin
        vsReg <= '0;
        vcReg <= '0;
        yReg  <= yIn;
        nReg  <= nIn;
      end else if (ctl.csStep) begin
        vsReg <= accS;
        vcReg <= accC;
      end else if (ctl.cpStep) begin
        vsReg    <= {digSum[DIG-1:0], vsReg[W-1:DIG]};
        vcReg    <= vcReg >> DIG;
        outDigit <= digSum[DIG-1:0];
      end
      if (ctl.clrCarry)    cinReg <= '0;
      else if (ctl.cpStep) cinReg <= cinNext;
    end
  end

  // R3: the result fits in W bits, so nothing is left over after resolving
  p_carry_drained_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cpStep && ctl.lastStep) |=> (cinReg == '0 && vcReg == '0));

endmodule

// File: rtl/mont_digit_mul.sv
module mont_digit_mul
  import mdm_pkg::*;
#(
  parameter int unsigned KW    = 32,
  parameter int unsigned ALPHA = 4,
  parameter int unsigned DIG   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  opAdd,
  input  logic [DIG-1:0]        xDigit,
  input  logic [DIG-1:0]        sDigit,
  input  logic [KW+ALPHA-1:0]   yIn,
  input  logic [KW+ALPHA-1:0]   nIn,
  output logic                  busy,
  output logic                  xLoad,
  output logic                  sLoad,
  output logic [DIG-1:0]        outDigit,
  output logic                  outValid,
  output logic                  done
);

  localparam int unsigned W     = KW + ALPHA;
  localparam int unsigned STEPS = W / DIG;

  if ((W % DIG) != 0 || DIG < 2) begin : g_badDigit
    $error("digit size must be at least 2 and divide KW+ALPHA");
  end

  dpCtl_t ctl;

  mdm_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opAdd    (opAdd),
    .ctl      (ctl),
    .busy     (busy),
    .xLoad    (xLoad),
    .sLoad    (sLoad),
    .outValid (outValid),
    .done     (done)
  );

  mdm_datapath #(.W(W), .DIG(DIG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .xDigit   (xDigit),
    .sDigit   (sDigit),
    .yIn      (yIn),
    .nIn      (nIn),
    .outDigit (outDigit)
  );

endmodule

// File: tb/mont_digit_mul_test.sv
`timescale 1ns/1ps
module mont_digit_mul_test;

  localparam int unsigned KW    = 32;
  localparam int unsigned ALPHA = 4;
  localparam int unsigned DIG   = 4;
  localparam int unsigned W     = KW + ALPHA;
  localparam int unsigned D     = W / DIG;
  localparam int unsigned NVEC  = 6;

  localparam logic [W-1:0] VN [NVEC] = '{36'h0FFFFFFFB, 36'h0FFFFFFFB, 36'h000000003,
                                         36'h080000001, 36'h0DEADBEEF, 36'h0C0FFEE01};
  localparam logic [W-1:0] VX [NVEC] = '{36'h000000001, 36'h1FFFFFFF5, 36'h000000005,
                                         36'h012345678, 36'h000000000, 36'h17FFFFFFF};
  localparam logic [W-1:0] VY [NVEC] = '{36'h000000001, 36'h1FFFFFFF5, 36'h000000004,
                                         36'h09ABCDEF0, 36'h000001234, 36'h100000000};
  localparam logic [W-1:0] VS [NVEC] = '{36'h000000000, 36'h1FFFFFFF5, 36'h000000002,
                                         36'h00F0F0F0F, 36'h0ABCDEF01, 36'h000000000};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opAdd = 1'b0;
  logic [DIG-1:0] xDigit = '0;
  logic [DIG-1:0] sDigit = '0;
  logic [W-1:0] yIn = '0;
  logic [W-1:0] nIn = '0;
  logic busy, xLoad, sLoad, outValid, done;
  logic [DIG-1:0] outDigit;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mont_digit_mul #(.KW(KW), .ALPHA(ALPHA), .DIG(DIG)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opAdd(opAdd),
    .xDigit(xDigit), .sDigit(sDigit), .yIn(yIn), .nIn(nIn),
    .busy(busy), .xLoad(xLoad), .sLoad(sLoad),
    .outDigit(outDigit), .outValid(outValid), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] refMod(input logic [W-1:0] x, y, s, n);
    logic [127:0] v;
    v = ({92'd0, x} * {92'd0, y}) % {92'd0, n};
    for (int i = 0; i < W; i++) begin
      if (v[0]) v = v + {92'd0, n};
      v = v >> 1;
    end
    return (v + {92'd0, s}) % {92'd0, n};
  endfunction

  task automatic runOp(input bit addOnly, input logic [W-1:0] x, y, n, s,
                       input bit poke, output logic [W-1:0] res);
    res = '0;
    @(negedge clk);
    start = 1'b1; opAdd = addOnly; yIn = y; nIn = n;
    @(negedge clk);
    start = 1'b0; opAdd = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    if (!addOnly) begin
      for (int j = 0; j < D; j++) begin
        chk(xLoad && !sLoad, "R2 x pass strobes", 64'({xLoad, sLoad}), 64'd2);
        xDigit = x[j*DIG +: DIG];
        if (poke && j == 1) begin start = 1'b1; opAdd = 1'b1; end
        @(negedge clk);
        start = 1'b0; opAdd = 1'b0;
        chk(busy == 1'b1, "R7 busy in x pass", 64'(busy), 64'd1);
      end
    end
    for (int j = 0; j < D; j++) begin
      chk(sLoad && !xLoad, addOnly ? "R6 add-only strobes" : "R2 s pass strobes",
          64'({xLoad, sLoad}), 64'd1);
      sDigit = s[j*DIG +: DIG];
      if (poke && j == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(outValid == 1'b1, "R4 digit valid", 64'(outValid), 64'd1);
      chk(done == (j == D - 1), "R4 done on last digit only", 64'(done), 64'(j == D - 1));
      chk(busy == 1'b1, "R7 busy while digits", 64'(busy), 64'd1);
      res[j*DIG +: DIG] = outDigit;
    end
    chk(!sLoad && !xLoad, "R5 passes ended", 64'({xLoad, sLoad}), 64'd0);
    @(negedge clk);
    chk(!busy && !outValid && !done, "R5 idle after last digit",
        64'({busy, outValid, done}), 64'd0);
  endtask

  task automatic checkMul(input string tag, input int idx, input logic [W-1:0] res);
    logic [127:0] expv, got;
    expv = refMod(VX[idx], VY[idx], VS[idx], VN[idx]);
    got  = {92'd0, res} % {92'd0, VN[idx]};
    chk(got == expv, tag, got[63:0], expv[63:0]);
    chk((res >> (KW + 2)) == '0, "R3 result bound", 64'(res), 64'(1) << (KW + 2));
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] res, prev, sAdd;
    repeat (2) @(negedge clk);
    chk(!busy && !xLoad && !sLoad && !outValid && !done, "R1 in reset",
        64'({busy, xLoad, sLoad, outValid, done}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !xLoad && !sLoad && !outValid && !done, "R1 after reset",
        64'({busy, xLoad, sLoad, outValid, done}), 64'd0);

    // vector table walk (R3, R8: every multiply starts from a cleared pair)
    for (int i = 0; i < NVEC; i++) begin
      runOp(1'b0, VX[i], VY[i], VN[i], VS[i], 1'b0, res);
      checkMul("R3 R8 multiply-add vector", i, res);
    end

    // chained add-only on the stored result (R6)
    runOp(1'b0, VX[3], VY[3], VN[3], VS[3], 1'b0, prev);
    sAdd = 36'h123456789;
    runOp(1'b1, '0, '0, '0, sAdd, 1'b0, res);
    chk(res == prev + sAdd, "R6 add-only exact sum", 64'(res), 64'(prev + sAdd));
    prev = res;
    runOp(1'b1, '0, '0, '0, '0, 1'b0, res);
    chk(res == prev, "R6 stored pair holds result", 64'(res), 64'(prev));

    // multiply after adds must not see the stored pair (R8)
    runOp(1'b0, VX[2], VY[2], VN[2], VS[2], 1'b0, res);
    checkMul("R8 cleared before multiply", 2, res);

    // starts while busy are ignored (R7)
    runOp(1'b0, VX[5], VY[5], VN[5], VS[5], 1'b1, res);
    checkMul("R7 start while busy ignored", 5, res);
    prev = res;
    runOp(1'b1, '0, '0, '0, 36'h000000007, 1'b1, res);
    chk(res == prev + 36'h7, "R7 add-only with busy start", 64'(res), 64'(prev + 36'h7));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule